// File: doc/BRIEF.md
# Four-Lane PCS Control and Status Register Block

This block is the software-visible register file of a four-lane 10G physical coding sublayer. The lane synchronisation, alignment and receive state machines sit outside it. Their live outputs arrive as input pins:

- per-lane bit lock
- per-lane code-group sync
- the lane-aligned flag
- per-lane sync-machine bad state
- receive-machine bad state
- a per-lane pulse on each first-to-second acquired-state transition
- transmit and receive fault conditions

The block turns these into several kinds of register state:

- latching status bits
- a fault summary
- sticky interrupt causes with a separate enable for each cause
- one combined interrupt line

Software uses a simple single-cycle register port. A write takes effect on the clock edge where `reg_wr` is high. Read data is combinational from the addressed register. A read has its side effects on the clock edge where `reg_rd` is high. Addresses are: 0 control, 1 status one, 2 status two, 3 PCS type, 4 live lane status, 5 interrupt causes, 6 interrupt enables. Address 7 reads 0.

The control register holds a loopback enable and a self-clearing reset request. The reset request is sequenced by a two-state machine:

- RST_IDLE: the reset output is low.
- RST_IDLE to RST_ACTIVE: taken on a control write with bit 15 set.
- RST_ACTIVE: the reset output is high while a counter runs.
- RST_ACTIVE to RST_IDLE: taken when the counter reaches the last of 32 cycles.

Top module: `pcs_csr_block`

## Requirements
- R1: After reset, control (addr 0) reads 0x2040: bit 13 and bit 6 are 1, speed bits 5:2 are 0. PCS type (addr 3) reads 0x0001. Status two reads 0x8002: device field 15:14 = 2'b10, bit 1 = 1. Status one bit 1 (low-power ability) is 1. Writes to these constant fields have no effect.
- R2: The live status register (addr 4) shows lane sync 3:0 in bits 3:0 and the aligned flag in bit 12. The pattern-test bit 11 always reads 0.
- R3: Status one bit 2 (receive link) is a latching-low copy of the aligned input. It reads 0 after reset. Once alignment drops it stays 0, even after alignment returns, until a read of status one. That read reloads it from the live flag.
- R4: Status two bit 11 (transmit fault) and bit 10 (receive fault) latch high on their condition. They hold until a read of status two. Status one bit 7 is the OR of the two latched faults.
- R5: A read in the same cycle as a new fault returns the previous value. The new fault stays latched for the next read.
- R6: The loss causes fire only on the falling edge of their live input, never on a steady low. The cause bits are: bit 5 alignment loss, bit 4 sync loss on any lane, bit 3 bit-lock loss on any lane.
- R7: Cause bit 2 sets while any lane's sync machine is bad. Bit 1 sets while the receive machine is bad. Bit 6 sets on any lane's sync-debug pulse. Bit 0 (transmit fault cause) always reads 0.
- R8: Cause bits (addr 5) are sticky and cleared by writing 1 to them. A new event in the same cycle as the clear leaves the bit set.
- R9: The enable register (addr 6, bits 6:0) reads back as written. `irq` is high while any cause bit and its enable bit are both 1.
- R10: Writing 1 to control bit 15 raises `pcs_reset` for exactly 32 cycles, and bit 15 reads 1 during that time. It then returns to 0 by itself. A further request during the sequence does not extend it.
- R11: Control bit 14 is a loopback enable. It reads back as written and drives `loopback_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| lane_bitlock | input | 4 | Live per-lane bit lock |
| lane_sync | input | 4 | Live per-lane code-group sync |
| lanes_aligned | input | 1 | Live lane alignment flag |
| lane_sync_bad | input | 4 | Per-lane sync machine in bad state |
| rx_machine_bad | input | 1 | Receive machine in bad state |
| sync_dbg_pulse | input | 4 | Per-lane first-to-second acquired transition pulse |
| tx_fault_cond | input | 1 | Transmit fault condition |
| rx_fault_cond | input | 1 | Receive fault condition |
| irq | output | 1 | Combined enabled interrupt |
| pcs_reset | output | 1 | Software-requested PCS reset |
| loopback_en | output | 1 | Loopback enable |

## Verification
The hardest situations to reach are the exact coincidences: a status read landing on the same edge as a fresh fault, and a write-one-clear landing on the same edge as a new cause event. The bench does not use its access tasks for these. It drives the strobe and the event input in the same low clock phase, then reads back on the following access to show that nothing was lost. Proving that a loss cause does not refire requires holding the input low for many cycles after a clear, then reading the cause register before the input is restored. The reset sequence is counted cycle by cycle from the bench, with a second request injected part-way through.

// File: rtl/pcs_csr_pkg.sv
package pcs_csr_pkg;

    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 3;
    localparam int NUM_LANES = 4;
    localparam int N_CAUSE   = 7;

    // cause bit positions (cause and enable registers share them)
    localparam int C_TXFLT   = 0;
    localparam int C_RXBAD   = 1;
    localparam int C_SYNBAD  = 2;
    localparam int C_BLKLOSS = 3;
    localparam int C_SYNLOSS = 4;
    localparam int C_ALNLOSS = 5;
    localparam int C_DBGSYNC = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_STAT1  = 3'd1,
        A_STAT2  = 3'd2,
        A_TYPE   = 3'd3,
        A_LIVE   = 3'd4,
        A_ICAUSE = 3'd5,
        A_IEN    = 3'd6,
        A_NONE   = 3'd7
    } csr_addr_e;

    typedef enum logic {
        RST_IDLE   = 1'b0,
        RST_ACTIVE = 1'b1
    } rst_state_e;

endpackage

// File: rtl/pcs_csr_rstseq.sv
module pcs_csr_rstseq
    import pcs_csr_pkg::*;
#(
    parameter int RST_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    output logic rst_active
);

    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    rst_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RST_IDLE:   if (start_req)     state_d = RST_ACTIVE;
            RST_ACTIVE: if (cnt_q == LAST) state_d = RST_IDLE;
            default:                       state_d = RST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RST_IDLE;
        else        state_q <= state_d;
    end

    // cycle counter, restarted on entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (state_q == RST_IDLE) cnt_q <= '0;
        else                          cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RST_IDLE:   rst_active = 1'b0;
            RST_ACTIVE: rst_active = 1'b1;
            default:    rst_active = 1'b0;
        endcase
    end

    // R10
    rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !rst_active) |=> rst_active);

    // R10
    rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/pcs_csr_latch.sv
module pcs_csr_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic aligned,
    input  logic tx_cond,
    input  logic rx_cond,
    input  logic rd_stat1,
    input  logic rd_stat2,
    output logic link_lat,
    output logic tx_lat,
    output logic rx_lat
);

    // a read reloads from the live value seen on that same edge, so an
    // event coinciding with the read is kept for the next read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            link_lat <= 1'b0;
        end else if (rd_stat1) begin
            link_lat <= aligned;
        end else begin
            link_lat <= link_lat & aligned;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_lat <= 1'b0;
            rx_lat <= 1'b0;
        end else if (rd_stat2) begin
            tx_lat <= tx_cond;
            rx_lat <= rx_cond;
        end else begin
            tx_lat <= tx_lat | tx_cond;
            rx_lat <= rx_lat | rx_cond;
        end
    end

    // R3
    link_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_lat && !rd_stat1) |=> !link_lat);

    // R4
    tx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cond |=> tx_lat);

    // R4
    rx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cond |=> rx_lat);

    // R5
    fault_read_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat2 && rx_cond) |=> rx_lat);

endmodule

// File: rtl/pcs_csr_irq.sv
module pcs_csr_irq
    import pcs_csr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_bitlock,
    input  logic [NUM_LANES-1:0] lane_sync,
    input  logic [NUM_LANES-1:0] lane_sync_bad,
    input  logic [NUM_LANES-1:0] sync_dbg_evt,
    input  logic                 aligned,
    input  logic                 rx_machine_bad,
    input  logic                 clr_wr,
    input  logic                 en_wr,
    input  logic [N_CAUSE-1:0]   wr_bits,
    output logic [N_CAUSE-1:0]   cause_q,
    output logic [N_CAUSE-1:0]   en_q,
    output logic                 irq
);

    logic [NUM_LANES-1:0] bitlock_prev, sync_prev;
    logic [NUM_LANES-1:0] bitlock_fall, sync_fall;
    logic                 align_prev;
    logic [N_CAUSE-1:0]   evt, cause_d, clr_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitlock_prev <= '0;
            sync_prev    <= '0;
            align_prev   <= 1'b0;
        end else begin
            bitlock_prev <= lane_bitlock;
            sync_prev    <= lane_sync;
            align_prev   <= aligned;
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane_edge
        assign bitlock_fall[g] = bitlock_prev[g] & ~lane_bitlock[g];
        assign sync_fall[g]    = sync_prev[g]    & ~lane_sync[g];
    end

    always_comb begin
        evt            = '0;
        evt[C_TXFLT]   = 1'b0;
        evt[C_RXBAD]   = rx_machine_bad;
        evt[C_SYNBAD]  = |lane_sync_bad;
        evt[C_BLKLOSS] = |bitlock_fall;
        evt[C_SYNLOSS] = |sync_fall;
        evt[C_ALNLOSS] = align_prev & ~aligned;
        evt[C_DBGSYNC] = |sync_dbg_evt;
    end

    assign clr_mask = clr_wr ? wr_bits : '0;
    assign cause_d  = (cause_q & ~clr_mask) | evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= '0;
            en_q    <= '0;
        end else begin
            cause_q <= cause_d;
            if (en_wr) en_q <= wr_bits;
        end
    end

    assign irq = |(cause_q & en_q);

    for (genvar k = 0; k < N_CAUSE; k++) begin : g_cause_chk
        // R8
        cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            evt[k] |=> cause_q[k]);
    end

    // R6
    align_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!align_prev && !aligned && !cause_q[C_ALNLOSS] && !en_wr)
            |=> !cause_q[C_ALNLOSS]);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cause_d & en_q) != '0 || $past(en_wr)));

endmodule

// File: rtl/pcs_csr_block.sv
module pcs_csr_block
    import pcs_csr_pkg::*;
#(
    parameter int RST_CYCLES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [3:0]        lane_bitlock,
    input  logic [3:0]        lane_sync,
    input  logic              lanes_aligned,
    input  logic [3:0]        lane_sync_bad,
    input  logic              rx_machine_bad,
    input  logic [3:0]        sync_dbg_pulse,
    input  logic              tx_fault_cond,
    input  logic              rx_fault_cond,
    output logic              irq,
    output logic              pcs_reset,
    output logic              loopback_en
);

    csr_addr_e addr;
    logic wr_ctrl, wr_cause, wr_en, rd_s1, rd_s2;
    logic loopback_q, rst_active;
    logic link_lat, tx_lat, rx_lat;
    logic [N_CAUSE-1:0] cause_q, en_q;
    logic unused_wbits;

    assign addr     = csr_addr_e'(reg_addr);
    assign wr_ctrl  = reg_wr && (addr == A_CTRL);
    assign wr_cause = reg_wr && (addr == A_ICAUSE);
    assign wr_en    = reg_wr && (addr == A_IEN);
    assign rd_s1    = reg_rd && (addr == A_STAT1);
    assign rd_s2    = reg_rd && (addr == A_STAT2);
    assign unused_wbits = ^reg_wdata[13:7];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       loopback_q <= 1'b0;
        else if (wr_ctrl) loopback_q <= reg_wdata[14];
    end

    pcs_csr_rstseq #(.RST_CYCLES(RST_CYCLES)) u_rstseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_req  (wr_ctrl && reg_wdata[15]),
        .rst_active (rst_active)
    );

    pcs_csr_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .aligned  (lanes_aligned),
        .tx_cond  (tx_fault_cond),
        .rx_cond  (rx_fault_cond),
        .rd_stat1 (rd_s1),
        .rd_stat2 (rd_s2),
        .link_lat (link_lat),
        .tx_lat   (tx_lat),
        .rx_lat   (rx_lat)
    );

    pcs_csr_irq u_irq (
        .clk            (clk),
        .rst_n          (rst_n),
        .lane_bitlock   (lane_bitlock),
        .lane_sync      (lane_sync),
        .lane_sync_bad  (lane_sync_bad),
        .sync_dbg_evt   (sync_dbg_pulse),
        .aligned        (lanes_aligned),
        .rx_machine_bad (rx_machine_bad),
        .clr_wr         (wr_cause),
        .en_wr          (wr_en),
        .wr_bits        (reg_wdata[N_CAUSE-1:0]),
        .cause_q        (cause_q),
        .en_q           (en_q),
        .irq            (irq)
    );

    always_comb begin
        unique case (addr)
            A_CTRL:   reg_rdata = {rst_active, loopback_q, 1'b1, 6'b0, 1'b1, 4'b0000, 2'b00};
            A_STAT1:  reg_rdata = {8'b0, (tx_lat | rx_lat), 4'b0, link_lat, 1'b1, 1'b0};
            A_STAT2:  reg_rdata = {2'b10, 2'b00, tx_lat, rx_lat, 7'b0, 3'b010};
            A_TYPE:   reg_rdata = 16'h0001;
            A_LIVE:   reg_rdata = {3'b0, lanes_aligned, 1'b0, 7'b0, lane_sync};
            A_ICAUSE: reg_rdata = {{(DATA_W-N_CAUSE){1'b0}}, cause_q};
            A_IEN:    reg_rdata = {{(DATA_W-N_CAUSE){1'b0}}, en_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign pcs_reset   = rst_active;
    assign loopback_en = loopback_q;

    // R11
    loopback_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (loopback_en == $past(reg_wdata[14])));

    // R4
    fault_summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fault_cond || rx_fault_cond) |=> (addr != A_STAT1) || reg_rdata[7]);

endmodule

// File: tb/test_pcs_csr_block.sv
`timescale 1ns/1ps
module test_pcs_csr_block;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd;
    logic [2:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic [3:0]  lane_bitlock, lane_sync, lane_sync_bad, sync_dbg_pulse;
    logic        lanes_aligned, rx_machine_bad, tx_fault_cond, rx_fault_cond;
    logic        irq, pcs_reset, loopback_en;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [2:0] CTRL = 0, STAT1 = 1, STAT2 = 2, TYPE = 3, LIVE = 4, ICAUSE = 5, IEN = 6;

    always #2.5 clk = ~clk;

    pcs_csr_block i_pcs_csr_block (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lane_bitlock(lane_bitlock), .lane_sync(lane_sync),
        .lanes_aligned(lanes_aligned), .lane_sync_bad(lane_sync_bad),
        .rx_machine_bad(rx_machine_bad), .sync_dbg_pulse(sync_dbg_pulse),
        .tx_fault_cond(tx_fault_cond), .rx_fault_cond(rx_fault_cond),
        .irq(irq), .pcs_reset(pcs_reset), .loopback_en(loopback_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [15:0] v;
        chk("R1 irq", {15'b0, irq}, 16'h0);
        chk("R10 pcs_reset idle", {15'b0, pcs_reset}, 16'h0);
        chk("R11 loopback idle", {15'b0, loopback_en}, 16'h0);
        rd(CTRL, v);   chk("R1 ctrl", v, 16'h2040);
        rd(TYPE, v);   chk("R1 type", v, 16'h0001);
        rd(STAT2, v);  chk("R1 stat2", v, 16'h8002);
        rd(ICAUSE, v); chk("R1 causes", v, 16'h0000);
        wr(CTRL, 16'h3FFF); rd(CTRL, v); chk("R1 ctrl const", v, 16'h2040);
        wr(TYPE, 16'hFFFF); rd(TYPE, v); chk("R1 type const", v, 16'h0001);
        wr(STAT2, 16'hFFFF); rd(STAT2, v); chk("R1 stat2 const", v, 16'h8002);
    endtask

    task automatic t_live();
        logic [15:0] v;
        @(negedge clk); lane_sync = 4'b1010;
        rd(LIVE, v); chk("R2 live 1010", v, 16'h100A);
        @(negedge clk); lane_sync = 4'b1111; lanes_aligned = 1'b0;
        rd(LIVE, v); chk("R2 live unaligned", v, 16'h000F);
        @(negedge clk); lanes_aligned = 1'b1;
        rd(LIVE, v); chk("R2 live full", v, 16'h100F);
        wr(ICAUSE, 16'h007F);
    endtask

    task automatic t_link();
        logic [15:0] v;
        rd(STAT1, v); chk("R3 link after reset", v, 16'h0002);
        rd(STAT1, v); chk("R3 link reload", v, 16'h0006);
        @(negedge clk); lanes_aligned = 1'b0;
        @(negedge clk); lanes_aligned = 1'b1;
        repeat (3) @(negedge clk);
        rd(STAT1, v); chk("R3 link latched low", v, 16'h0002);
        rd(STAT1, v); chk("R3 link after read", v, 16'h0006);
        wr(ICAUSE, 16'h007F);
    endtask

    task automatic t_fault();
        logic [15:0] v;
        @(negedge clk); tx_fault_cond = 1'b1;
        @(negedge clk); tx_fault_cond = 1'b0;
        repeat (2) @(negedge clk);
        rd(STAT1, v); chk("R4 summary tx", v, 16'h0086);
        rd(STAT2, v); chk("R4 tx latched", v, 16'h8802);
        rd(STAT2, v); chk("R4 tx cleared", v, 16'h8002);
        rd(STAT1, v); chk("R4 summary clear", v, 16'h0006);
        @(negedge clk); rx_fault_cond = 1'b1;
        @(negedge clk); rx_fault_cond = 1'b0;
        rd(STAT1, v); chk("R4 summary rx", v, 16'h0086);
        rd(STAT2, v); chk("R4 rx latched", v, 16'h8402);
        // R5: read coinciding with a new receive fault
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = STAT2; rx_fault_cond = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; rx_fault_cond = 1'b0;
        chk("R5 read returns prior", v, 16'h8002);
        rd(STAT2, v); chk("R5 event kept", v, 16'h8402);
        rd(STAT2, v); chk("R5 then cleared", v, 16'h8002);
    endtask

    task automatic t_causes();
        logic [15:0] v;
        wr(ICAUSE, 16'h007F);
        wr(IEN, 16'h007F);
        rd(IEN, v); chk("R9 enable readback", v, 16'h007F);
        chk("R9 irq quiet", {15'b0, irq}, 16'h0);
        // R6 bit-lock loss, then steady low
        @(negedge clk); lane_bitlock = 4'b1011;
        repeat (5) @(negedge clk);
        rd(ICAUSE, v); chk("R6 bitlock loss", v, 16'h0008);
        chk("R9 irq set", {15'b0, irq}, 16'h1);
        wr(ICAUSE, 16'h0008);
        repeat (4) @(negedge clk);
        rd(ICAUSE, v); chk("R6 steady low no refire", v, 16'h0000);
        chk("R9 irq cleared", {15'b0, irq}, 16'h0);
        @(negedge clk); lane_bitlock = 4'b1111;
        rd(ICAUSE, v); chk("R6 rising ignored", v, 16'h0000);
        // sync loss
        @(negedge clk); lane_sync = 4'b1110;
        @(negedge clk); lane_sync = 4'b1111;
        rd(ICAUSE, v); chk("R6 sync loss", v, 16'h0010);
        wr(ICAUSE, 16'h0010);
        // alignment loss
        @(negedge clk); lanes_aligned = 1'b0;
        @(negedge clk); lanes_aligned = 1'b1;
        rd(ICAUSE, v); chk("R6 align loss", v, 16'h0020);
        wr(ICAUSE, 16'h007F);
        rd(STAT1, v); rd(STAT1, v);
        // level and pulse causes, transmit fault cause stays 0
        @(negedge clk); lane_sync_bad = 4'b1000; rx_machine_bad = 1'b1;
        sync_dbg_pulse = 4'b0010; tx_fault_cond = 1'b1;
        @(negedge clk); lane_sync_bad = 4'b0; rx_machine_bad = 1'b0;
        sync_dbg_pulse = 4'b0; tx_fault_cond = 1'b0;
        rd(ICAUSE, v); chk("R7 level and debug causes", v, 16'h0046);
        rd(STAT2, v);
        wr(ICAUSE, 16'h007F);
        rd(ICAUSE, v); chk("R8 write one clears", v, 16'h0000);
        // R9 enable mask
        wr(IEN, 16'h003F);
        @(negedge clk); sync_dbg_pulse = 4'b0001;
        @(negedge clk); sync_dbg_pulse = 4'b0;
        rd(ICAUSE, v); chk("R9 masked cause visible", v, 16'h0040);
        chk("R9 masked irq low", {15'b0, irq}, 16'h0);
        wr(IEN, 16'h007F);
        chk("R9 enabled irq high", {15'b0, irq}, 16'h1);
        // R8 set wins over clear
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ICAUSE; reg_wdata = 16'h0040; sync_dbg_pulse = 4'b0100;
        @(negedge clk);
        reg_wr = 1'b0; sync_dbg_pulse = 4'b0;
        rd(ICAUSE, v); chk("R8 set wins", v, 16'h0040);
        wr(ICAUSE, 16'h007F);
        wr(IEN, 16'h0000);
    endtask

    task automatic t_loopback();
        logic [15:0] v;
        wr(CTRL, 16'h4000);
        chk("R11 loopback pin", {15'b0, loopback_en}, 16'h1);
        rd(CTRL, v); chk("R11 loopback read", v, 16'h6040);
        wr(CTRL, 16'h0000);
        chk("R11 loopback off", {15'b0, loopback_en}, 16'h0);
    endtask

    task automatic t_softreset();
        int cnt = 0;
        logic [15:0] v = 16'h0;
        wr(CTRL, 16'h8000);
        for (int i = 0; i < 60; i++) begin
            if (pcs_reset) cnt++;
            reg_wr = 1'b0; reg_rd = 1'b0;
            if (i == 3) begin
                reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 16'h8000;
            end
            if (i == 10) begin
                reg_rd = 1'b1; reg_addr = CTRL;
                #1 v = reg_rdata;
            end
            @(negedge clk);
        end
        reg_wr = 1'b0; reg_rd = 1'b0;
        chk("R10 ctrl bit during reset", v, 16'hA040);
        chk("R10 reset length", 16'(cnt), 16'd32);
        rd(CTRL, v); chk("R10 self clear", v, 16'h2040);
    endtask

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        lane_bitlock = 4'hF; lane_sync = 4'hF; lanes_aligned = 1'b1;
        lane_sync_bad = 4'h0; rx_machine_bad = 1'b0; sync_dbg_pulse = 4'h0;
        tx_fault_cond = 1'b0; rx_fault_cond = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state();
        t_live();
        t_link();
        t_fault();
        t_causes();
        t_loopback();
        t_softreset();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule